// File: doc/BRIEF.md
# Cascadable Line Capture for a Column Driver

This block gathers one display line of pixel codes for a column driver that shares a data bus with other drivers in a chain. On each clock the bus carries one word of `DOTS` dots of `DOT_W` bits each. The default is six 6-bit dots, 36 bits in all. A start pulse arms the block. The block then writes the next `SLOTS` words into consecutive word slots, which gives `SLOTS*DOTS` dot registers (384 by default). It then hands a one-clock start pulse to the next driver in the chain and stops listening to the bus by itself. Until the next line's capture overwrites it, the captured line stays visible on a flat output vector.

The direction input picks which start pin is the input and which is the output. It also picks the order in which the slots fill. Each half of the incoming word has its own inversion control, applied as the word is stored. A rising edge on the line strobe clears the capture sequence so that the next start pulse is accepted.

The sequencer has four states:
- `ST_IDLE`: waiting for a start.
- `ST_FILL`: writing slots.
- `ST_TAIL`: `TAIL_CLKS` clocks (default 2) with no writes.
- `ST_HALT`: capture stopped.

Its transitions are:
- start-accept: `ST_IDLE` to `ST_FILL`.
- fill-done: `ST_FILL` to `ST_TAIL`, on the `SLOTS`-th write.
- tail-done: `ST_TAIL` to `ST_HALT`.
- strobe-clear: any state to `ST_IDLE`, on a strobe rising edge. This transition takes priority over all others.

Top module: `dline_loader`

## Requirements
- R1: After reset, both start outputs are low, every dot register reads zero, and the block is idle.
- R2: With `dir_i` high, a rising edge of the clock that samples `start_r_i` high while idle is edge E0. The word present at edge Ek (k = 1..SLOTS) is stored in slot k-1. Dot i of slot s appears at `line_o[(s*DOTS+i)*DOT_W +: DOT_W]`, with bit 0 as the LSB.
- R3: With `dir_i` low, the start comes from `start_l_i`, and the word present at edge Ek is stored in slot SLOTS-k. The order of the dots inside a slot is unchanged.
- R4: When `inv_lo_i` is high at a write edge, dots 0 to DOTS/2-1 of that word are stored bitwise inverted. When it is low, they are stored unchanged.
- R5: When `inv_hi_i` is high at a write edge, dots DOTS/2 to DOTS-1 of that word are stored bitwise inverted. When it is low, they are stored unchanged.
- R6: After edge E(SLOTS), the start output on the pin opposite the start input goes high for exactly one clock. That pin is `start_l_o` when the direction is high and `start_r_o` when it is low. At all other times both start outputs are low.
- R7: From edge E(SLOTS+1) on, through the end of the tail and in the halted state, neither bus words nor start pulses change `line_o` or the start outputs.
- R8: A start input held high for several clocks counts only once. A start that is still high when the strobe clears the block is ignored until it has gone low and risen again.
- R9: A strobe rising edge in any state, including in the middle of a fill, returns the block to idle. No write occurs at that edge or after it, and the next accepted start fills from the first slot again.
- R10: Dot registers keep their contents through strobes and idle periods until a new capture overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction: 1 = start enters on the right pin and slots fill upward; 0 = start enters on the left pin and slots fill downward |
| start_r_i | input | 1 | Right-side start input (used when `dir_i` = 1) |
| start_l_i | input | 1 | Left-side start input (used when `dir_i` = 0) |
| start_r_o | output | 1 | Right-side start output to the next driver (direction 0) |
| start_l_o | output | 1 | Left-side start output to the next driver (direction 1) |
| strobe_i | input | 1 | Line strobe; its rising edge clears the sequence |
| word_i | input | DOTS*DOT_W | Bus word of DOTS dots, dot i in bits i*DOT_W upward |
| inv_lo_i | input | 1 | Inverts the lower half of the dots when they are stored |
| inv_hi_i | input | 1 | Inverts the upper half of the dots when they are stored |
| line_o | output | SLOTS*DOTS*DOT_W | Captured dot registers, dot position p in bits p*DOT_W upward |

## Verification
A word and its inversion controls, present at write edge Ek, pass through a single register stage. They are visible on `line_o` right after that edge. The hand-off pulse is registered from the last write: it is high from edge E(SLOTS) to edge E(SLOTS+1) and low otherwise. A strobe rising edge takes effect at the edge that samples it, so a word presented at that same edge is already discarded. The bench drives every input on the falling edge and samples on the falling edge. It checks the start outputs in every fill cycle, checks the hand-off in the one cycle it is due and in the cycle after, and compares the full line against an arithmetic model once the tail has begun.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_TAIL = 2'd2,
        ST_HALT = 2'd3
    } ldr_state_e;
endpackage

// File: rtl/dline_ctrl.sv
module dline_ctrl
    import ldr_pkg::*;
#(
    parameter int SLOTS     = 64,
    parameter int TAIL_CLKS = 2,
    localparam int SW       = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_i,
    input  logic          start_r_i,
    input  logic          start_l_i,
    input  logic          strobe_i,
    output logic          wr_en_o,
    output logic [SW-1:0] wr_slot_o,
    output logic          start_r_o,
    output logic          start_l_o
);
    localparam int CMAX = (SLOTS > TAIL_CLKS) ? SLOTS : TAIL_CLKS;
    localparam int CW   = $clog2(CMAX);

    ldr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          dir_q, dir_d;
    logic          start_q, strobe_q, fwd_q;
    logic          start_sel, start_rise, strobe_rise, fill_last;

    assign start_sel   = dir_i ? start_r_i : start_l_i;
    assign start_rise  = start_sel & ~start_q;
    assign strobe_rise = strobe_i & ~strobe_q;
    assign fill_last   = (state_q == ST_FILL) && (cnt_q == CW'(SLOTS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            dir_q    <= 1'b1;
            start_q  <= 1'b0;
            strobe_q <= 1'b0;
            fwd_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            dir_q    <= dir_d;
            start_q  <= start_sel;
            strobe_q <= strobe_i;
            fwd_q    <= fill_last && !strobe_rise;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dir_d   = dir_q;
        if (strobe_rise) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_rise) begin
                        state_d = ST_FILL;
                        cnt_d   = '0;
                        dir_d   = dir_i;
                    end
                end
                ST_FILL: begin
                    if (fill_last) begin
                        state_d = ST_TAIL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_TAIL: begin
                    if (cnt_q == CW'(TAIL_CLKS - 1)) begin
                        state_d = ST_HALT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en_o   = (state_q == ST_FILL) && !strobe_rise;
        wr_slot_o = dir_q ? cnt_q[SW-1:0] : (SW'(SLOTS - 1) - cnt_q[SW-1:0]);
        start_l_o = fwd_q & dir_q;
        start_r_o = fwd_q & ~dir_q;
    end

    // R6
    fwd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q |=> !fwd_q);

    // R6
    fwd_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q |-> (state_q == ST_TAIL));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !strobe_rise) |=> (state_q == ST_HALT));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !strobe_rise) |=> (state_q != ST_IDLE));

    // R9
    strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (state_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/dline_invert.sv
module dline_invert #(
    parameter int DOT_W = 6,
    parameter int DOTS  = 6,
    localparam int WW   = DOT_W * DOTS
) (
    input  logic [WW-1:0] word_i,
    input  logic          inv_lo_i,
    input  logic          inv_hi_i,
    output logic [WW-1:0] word_o
);
    for (genvar d = 0; d < DOTS; d++) begin : g_dot
        if (d < DOTS / 2) begin : g_lo
            assign word_o[d*DOT_W +: DOT_W] = word_i[d*DOT_W +: DOT_W] ^ {DOT_W{inv_lo_i}};
        end else begin : g_hi
            assign word_o[d*DOT_W +: DOT_W] = word_i[d*DOT_W +: DOT_W] ^ {DOT_W{inv_hi_i}};
        end
    end
endmodule

// File: rtl/dline_store.sv
module dline_store #(
    parameter int SLOTS  = 64,
    parameter int WORD_W = 36,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [SW-1:0]           wr_slot_i,
    input  logic [WORD_W-1:0]       word_i,
    output logic [SLOTS*WORD_W-1:0] line_o
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en_i && (wr_slot_i == SW'(s))) begin
                slot_q <= word_i;
            end
        end
        assign line_o[s*WORD_W +: WORD_W] = slot_q;
    end

    // R10
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(line_o));
endmodule

// File: rtl/dline_loader.sv
module dline_loader #(
    parameter int DOT_W = 6,
    parameter int DOTS  = 6,
    parameter int SLOTS = 64,
    localparam int WW   = DOT_W * DOTS,
    localparam int LW   = WW * SLOTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_i,
    input  logic          start_r_i,
    input  logic          start_l_i,
    output logic          start_r_o,
    output logic          start_l_o,
    input  logic          strobe_i,
    input  logic [WW-1:0] word_i,
    input  logic          inv_lo_i,
    input  logic          inv_hi_i,
    output logic [LW-1:0] line_o
);
    localparam int SW = $clog2(SLOTS);

    logic          wr_en;
    logic [SW-1:0] wr_slot;
    logic [WW-1:0] word_fix;

    dline_ctrl #(.SLOTS(SLOTS), .TAIL_CLKS(2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_i),
        .start_r_i (start_r_i),
        .start_l_i (start_l_i),
        .strobe_i  (strobe_i),
        .wr_en_o   (wr_en),
        .wr_slot_o (wr_slot),
        .start_r_o (start_r_o),
        .start_l_o (start_l_o)
    );

    dline_invert #(.DOT_W(DOT_W), .DOTS(DOTS)) u_inv (
        .word_i   (word_i),
        .inv_lo_i (inv_lo_i),
        .inv_hi_i (inv_hi_i),
        .word_o   (word_fix)
    );

    dline_store #(.SLOTS(SLOTS), .WORD_W(WW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .word_i    (word_fix),
        .line_o    (line_o)
    );

    // R6
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_r_o && start_l_o));
endmodule

// File: tb/dline_loader_tb.sv
module dline_loader_tb;
    localparam int DW   = 6;
    localparam int ND   = 6;
    localparam int NS   = 8;
    localparam int WW   = DW * ND;
    localparam int LW   = WW * NS;
    localparam int NPOS = NS * ND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir = 1'b1;
    logic          sr_i = 1'b0;
    logic          sl_i = 1'b0;
    logic          strobe = 1'b0;
    logic          inv_lo = 1'b0;
    logic          inv_hi = 1'b0;
    logic [WW-1:0] word = '0;
    logic          sr_o, sl_o;
    logic [LW-1:0] line;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [NPOS];

    always #10 clk = ~clk;

    dline_loader #(.DOT_W(DW), .DOTS(ND), .SLOTS(NS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir),
        .start_r_i (sr_i),
        .start_l_i (sl_i),
        .start_r_o (sr_o),
        .start_l_o (sl_o),
        .strobe_i  (strobe),
        .word_i    (word),
        .inv_lo_i  (inv_lo),
        .inv_hi_i  (inv_hi),
        .line_o    (line)
    );

    function automatic logic [DW-1:0] pat(int seed, int k, int i);
        int v;
        v = seed + k * 7 + i * 13;
        return v[DW-1:0];
    endfunction

    function automatic logic [WW-1:0] mk_word(int seed, int k);
        logic [WW-1:0] w;
        for (int i = 0; i < ND; i++) w[i*DW +: DW] = pat(seed, k, i);
        return w;
    endfunction

    task automatic chk_bit(string req, logic act, logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_line(string req);
        logic [LW-1:0] exp;
        int bad;
        bad = -1;
        for (int p = 0; p < NPOS; p++) exp[p*DW +: DW] = model[p];
        for (int p = NPOS - 1; p >= 0; p--)
            if (line[p*DW +: DW] !== exp[p*DW +: DW]) bad = p;
        checks = checks + 1;
        if (bad >= 0) begin
            errors = errors + 1;
            $display("FAIL %s: dot %0d actual %h expected %h", req, bad,
                     line[bad*DW +: DW], exp[bad*DW +: DW]);
        end
    endtask

    task automatic model_write(int k, int seed, logic d, logic il, logic ih);
        int slot;
        logic [DW-1:0] v;
        slot = d ? k : NS - 1 - k;
        for (int i = 0; i < ND; i++) begin
            v = pat(seed, k, i);
            if ((i < ND / 2) ? il : ih) v = ~v;
            model[slot*ND + i] = v;
        end
    endtask

    task automatic strobe_pulse();
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    // full line: start held for 'hold' edges, then NS words
    task automatic line_run(string req, logic d, int seed, logic il, logic ih, int hold);
        @(negedge clk);
        dir = d;
        if (d) sr_i = 1'b1; else sl_i = 1'b1;
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            chk_bit("R6", sr_o | sl_o, 1'b0);
            if (k + 1 >= hold) begin
                sr_i = 1'b0;
                sl_i = 1'b0;
            end
            word   = mk_word(seed, k);
            inv_lo = il;
            inv_hi = ih;
            model_write(k, seed, d, il, ih);
        end
        @(negedge clk);
        chk_bit("R6", d ? sl_o : sr_o, 1'b1);
        chk_bit("R6", d ? sr_o : sl_o, 1'b0);
        word = mk_word(seed + 40, 1);
        @(negedge clk);
        chk_bit("R6", sr_o | sl_o, 1'b0);
        chk_line(req);
    endtask

    task automatic junk_cycles(string req, int n, logic pulse);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk_bit(req, sr_o | sl_o, 1'b0);
            word   = mk_word(j * 5 + 3, j);
            inv_lo = j[0];
            inv_hi = j[1];
            if (pulse) begin
                sr_i = (j == 2);
                sl_i = (j == 4);
            end
        end
        sr_i = 1'b0;
        sl_i = 1'b0;
        chk_line(req);
    endtask

    initial begin
        #(20 * 150000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < NPOS; p++) model[p] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_bit("R1", sr_o, 1'b0);
        chk_bit("R1", sl_o, 1'b0);
        chk_line("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1", sr_o | sl_o, 1'b0);

        // sweep direction and both inversion controls
        for (int c = 0; c < 8; c++) begin
            logic d, il, ih;
            d  = c[2];
            il = c[0];
            ih = c[1];
            line_run(il ? "R4" : (ih ? "R5" : (d ? "R2" : "R3")), d, c * 9 + 1, il, ih, 1);
            junk_cycles("R7", 6, 1'b1);
            strobe_pulse();
            chk_line("R10");
        end

        // long start pulse counts once
        line_run("R8", 1'b1, 17, 1'b0, 1'b0, 3);
        junk_cycles("R7", 4, 1'b0);

        // start still high when strobe clears: ignored
        @(negedge clk);
        dir  = 1'b1;
        sr_i = 1'b1;
        strobe_pulse();
        for (int j = 0; j < NS + 4; j++) begin
            @(negedge clk);
            sr_i = 1'b1;
            word = mk_word(60, j);
            chk_bit("R8", sr_o | sl_o, 1'b0);
        end
        chk_line("R8");
        @(negedge clk);
        sr_i = 1'b0;
        line_run("R9", 1'b0, 23, 1'b1, 1'b0, 1);
        strobe_pulse();

        // strobe in the middle of a fill
        @(negedge clk);
        dir  = 1'b1;
        sr_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sr_i   = 1'b0;
            word   = mk_word(31, k);
            inv_lo = 1'b0;
            inv_hi = 1'b1;
            model_write(k, 31, 1'b1, 1'b0, 1'b1);
        end
        @(negedge clk);
        strobe = 1'b1;
        word   = mk_word(99, 3);
        @(negedge clk);
        strobe = 1'b0;
        junk_cycles("R9", NS + 4, 1'b0);
        chk_line("R10");
        line_run("R9", 1'b1, 45, 1'b0, 1'b0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule